// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block holds the page translations for the data side of a 32-bit memory management unit. A load/store unit presents a virtual address with a lookup enable. One clock later the block reports whether the page is present, the physical page number and the four access-permission bits: read and write, each for user and for supervisor mode. It also reports a cache-inhibit bit. With 8 KB pages and 64 entries, virtual address bits 18:13 pick the entry. Bits 31:19 are compared against the tag stored in that entry.

Software fills and inspects entries through a special-purpose-register port. The port has a chip select, a write strobe, an address and 32-bit data in each direction. Each entry is reached through two words, which sit in two separate address windows. The tag word holds the virtual tag and a valid flag. The mapping word holds the physical page number, the permissions and the cache-inhibit flag. Internally each entry is a narrow row. The row keeps only the tag bits that the index does not already imply. Raising exceptions, gating the bus and refilling entries all belong to the surrounding logic.

Top module: `dtlb_top`

## Requirements
- R1: Reset clears every entry, including its valid flag. After reset, no lookup reports a hit and every register read returns 0 until software writes the entry.
- R2: A write to address 0x0A00+n (n = 0..63) sets entry n's tag word. The tag is taken from data bits 31:19 and the valid flag from bit 0.
- R3: A write to address 0x0B00+n sets entry n's mapping word. The fields are taken from these data bits: physical page number from bits 31:13, supervisor-write from bit 9, supervisor-read from bit 8, user-write from bit 7, user-read from bit 6 and cache-inhibit from bit 1.
- R4: A read in either window returns the stored fields at the bit positions listed in R2 and R3, with every other bit 0. Outside a read, the data output is 0. This covers chip select low, a write cycle, and an address outside both windows.
- R5: When lookup_en is high in a cycle without a register access, hit_o, ppn_o, the permission outputs and ci_o reflect entry va[18:13] on the next cycle.
- R6: hit_o is 1 only if the selected entry is valid and its stored tag equals va[31:19] of the registered address.
- R7: A write to one word of an entry leaves the other word of that entry unchanged.
- R8: A register access inside either window takes precedence over a lookup in the same cycle. That lookup reports hit_o = 0 on the next cycle.
- R9: hit_o is 0 in any cycle that follows a cycle with lookup_en low.
- R10: A write whose address lies outside both windows changes no entry. Examples are 0x0A40 and 0x0C03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| lookup_en | input | 1 | Start a translation this cycle |
| lookup_va | input | 32 | Virtual address to translate |
| hit_o | output | 1 | Entry present and tag matched (one cycle after lookup) |
| ppn_o | output | 19 | Physical page number for address bits 31:13 |
| ure_o | output | 1 | User read permitted |
| uwe_o | output | 1 | User write permitted |
| sre_o | output | 1 | Supervisor read permitted |
| swe_o | output | 1 | Supervisor write permitted |
| ci_o | output | 1 | Cache inhibit |
| spr_cs | input | 1 | Register port select |
| spr_we | input | 1 | Register port write strobe |
| spr_addr | input | 32 | Register address |
| spr_wdata | input | 32 | Register write data |
| spr_rdata | output | 32 | Register read data |

## Verification
The bench writes words whose unused bits are all ones and reads them back. A design that stored or returned unimplemented bits, or that swapped permission bits, would return extra or misplaced ones. It writes just past the end of each window and then reads the neighbouring entries. A loose address decode would alias those writes onto entry 0 or entry 3. It aims lookups at a valid entry with the wrong tag, and at a matching tag whose valid flag is clear. A design that compared too few tag bits, or that ignored the valid flag, would report a false hit. It also runs a lookup alongside a register write to the same entry, and lookups back to back over all 64 entries. A design that let the lookup win the collision, or that was off by one cycle, would show the new entry's hit or a neighbour's page number.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // Register layout bit positions (software-visible)
  localparam int POS_VALID = 0;
  localparam int POS_CI    = 1;
  localparam int POS_URE   = 6;
  localparam int POS_SWE   = 9;

  // Register windows: tag words at 0x0A00, mapping words at 0x0B00
  localparam logic [31:0] WIN_BASE = 32'h0000_0A00;
  localparam int          HALF_BIT = 8;

  typedef struct packed {
    logic swe;
    logic sre;
    logic uwe;
    logic ure;
  } perm_t;

  typedef struct packed {
    logic in_win;
    logic xlat;
  } spr_dec_t;

  // Decode a register address against both windows for idx_w index bits
  function automatic spr_dec_t spr_decode(input logic [31:0] a, input int idx_w);
    spr_dec_t   d;
    logic [7:0] low_mask;
    low_mask = 8'((1 << idx_w) - 1);
    d.in_win = (a[31:9] == WIN_BASE[31:9]) && ((a[7:0] & ~low_mask) == 8'h00);
    d.xlat   = a[HALF_BIT];
    return d;
  endfunction

  function automatic logic [31:0] pack_match(input logic [31:0] tag_hi, input logic v);
    return tag_hi | (32'(v) << POS_VALID);
  endfunction

  function automatic logic [31:0] pack_xlat(input logic [31:0] ppn_hi, input perm_t p,
                                            input logic ci);
    return ppn_hi | (32'(p) << POS_URE) | (32'(ci) << POS_CI);
  endfunction

  function automatic perm_t unpack_perm(input logic [31:0] w);
    return perm_t'(w[POS_SWE:POS_URE]);
  endfunction

endpackage

// File: rtl/dtlb_spr_dec.sv
module dtlb_spr_dec
  import dtlb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             spr_cs,
  input  logic             spr_we,
  input  logic [31:0]      spr_addr,
  output logic             acc,
  output logic             wr_match,
  output logic             wr_xlat,
  output logic             rd_en,
  output logic             rd_xlat,
  output logic [IDX_W-1:0] idx
);

  spr_dec_t dec;

  always_comb begin
    dec      = spr_decode(spr_addr, IDX_W);
    acc      = spr_cs && dec.in_win;
    wr_match = acc && spr_we && !dec.xlat;
    wr_xlat  = acc && spr_we && dec.xlat;
    rd_en    = acc && !spr_we;
    rd_xlat  = dec.xlat;
    idx      = spr_addr[IDX_W-1:0];
  end

endmodule

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
#(
  parameter int ENTRY_CNT = 64,
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 13,
  parameter int PPN_W     = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_match,
  input  logic             wr_xlat,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  perm_t            wr_perm,
  input  logic             wr_ci,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic [TAG_W-1:0] lk_tag,
  output logic [PPN_W-1:0] lk_ppn,
  output perm_t            lk_perm,
  output logic             lk_ci,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn,
  output perm_t            rd_perm,
  output logic             rd_ci
);

  logic             valid_all [ENTRY_CNT];
  logic [TAG_W-1:0] tag_all   [ENTRY_CNT];
  logic [PPN_W-1:0] ppn_all   [ENTRY_CNT];
  perm_t            perm_all  [ENTRY_CNT];
  logic             ci_all    [ENTRY_CNT];

  for (genvar e = 0; e < ENTRY_CNT; e++) begin : g_row
    logic             v_r;
    logic [TAG_W-1:0] tag_r;
    logic [PPN_W-1:0] ppn_r;
    perm_t            perm_r;
    logic             ci_r;
    logic             sel;

    assign sel = (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        v_r   <= 1'b0;
        tag_r <= '0;
      end else if (wr_match && sel) begin
        v_r   <= wr_valid;
        tag_r <= wr_tag;
      end
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        ppn_r  <= '0;
        perm_r <= '0;
        ci_r   <= 1'b0;
      end else if (wr_xlat && sel) begin
        ppn_r  <= wr_ppn;
        perm_r <= wr_perm;
        ci_r   <= wr_ci;
      end
    end

    assign valid_all[e] = v_r;
    assign tag_all[e]   = tag_r;
    assign ppn_all[e]   = ppn_r;
    assign perm_all[e]  = perm_r;
    assign ci_all[e]    = ci_r;
  end

  assign lk_valid = valid_all[lk_idx];
  assign lk_tag   = tag_all[lk_idx];
  assign lk_ppn   = ppn_all[lk_idx];
  assign lk_perm  = perm_all[lk_idx];
  assign lk_ci    = ci_all[lk_idx];

  assign rd_valid = valid_all[rd_idx];
  assign rd_tag   = tag_all[rd_idx];
  assign rd_ppn   = ppn_all[rd_idx];
  assign rd_perm  = perm_all[rd_idx];
  assign rd_ci    = ci_all[rd_idx];

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int TAG_W = 13,
  parameter int PPN_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [TAG_W-1:0] va_tag,
  input  logic             row_valid,
  input  logic [TAG_W-1:0] row_tag,
  input  logic [PPN_W-1:0] row_ppn,
  input  perm_t            row_perm,
  input  logic             row_ci,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output perm_t            perm,
  output logic             ci
);

  logic             act_q;
  logic             v_q;
  logic [TAG_W-1:0] va_tag_q;
  logic [TAG_W-1:0] row_tag_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act_q     <= 1'b0;
      v_q       <= 1'b0;
      va_tag_q  <= '0;
      row_tag_q <= '0;
      ppn       <= '0;
      perm      <= '0;
      ci        <= 1'b0;
    end else begin
      act_q <= fire;
      if (fire) begin
        v_q       <= row_valid;
        va_tag_q  <= va_tag;
        row_tag_q <= row_tag;
        ppn       <= row_ppn;
        perm      <= row_perm;
        ci        <= row_ci;
      end
    end
  end

  assign hit = act_q && v_q && (row_tag_q == va_tag_q);

endmodule

// File: rtl/dtlb_top.sv
module dtlb_top
  import dtlb_pkg::*;
#(
  parameter int ENTRY_CNT  = 64,
  parameter int PAGE_SHIFT = 13,
  localparam int IDX_W     = $clog2(ENTRY_CNT),
  localparam int TAG_W     = 32 - PAGE_SHIFT - IDX_W,
  localparam int PPN_W     = 32 - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lookup_en,
  input  logic [31:0]      lookup_va,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             ure_o,
  output logic             uwe_o,
  output logic             sre_o,
  output logic             swe_o,
  output logic             ci_o,
  input  logic             spr_cs,
  input  logic             spr_we,
  input  logic [31:0]      spr_addr,
  input  logic [31:0]      spr_wdata,
  output logic [31:0]      spr_rdata
);

  // Named internal events for the checker
  logic             spr_acc;
  logic             lk_fire;
  logic             wr_match;
  logic             wr_xlat;
  logic             rd_en;
  logic             rd_xlat;
  logic [IDX_W-1:0] spr_idx;

  logic             lk_valid, rd_valid, lk_ci, rd_ci;
  logic [TAG_W-1:0] lk_tag, rd_tag;
  logic [PPN_W-1:0] lk_ppn, rd_ppn;
  perm_t            lk_perm, rd_perm, out_perm;
  logic             unused_bits;

  dtlb_spr_dec #(.IDX_W(IDX_W)) u_dec (
    .spr_cs   (spr_cs),
    .spr_we   (spr_we),
    .spr_addr (spr_addr),
    .acc      (spr_acc),
    .wr_match (wr_match),
    .wr_xlat  (wr_xlat),
    .rd_en    (rd_en),
    .rd_xlat  (rd_xlat),
    .idx      (spr_idx)
  );

  assign lk_fire = lookup_en && !spr_acc;

  dtlb_store #(
    .ENTRY_CNT (ENTRY_CNT),
    .IDX_W     (IDX_W),
    .TAG_W     (TAG_W),
    .PPN_W     (PPN_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_match (wr_match),
    .wr_xlat  (wr_xlat),
    .wr_idx   (spr_idx),
    .wr_valid (spr_wdata[POS_VALID]),
    .wr_tag   (spr_wdata[31 -: TAG_W]),
    .wr_ppn   (spr_wdata[31 -: PPN_W]),
    .wr_perm  (unpack_perm(spr_wdata)),
    .wr_ci    (spr_wdata[POS_CI]),
    .lk_idx   (lookup_va[PAGE_SHIFT +: IDX_W]),
    .lk_valid (lk_valid),
    .lk_tag   (lk_tag),
    .lk_ppn   (lk_ppn),
    .lk_perm  (lk_perm),
    .lk_ci    (lk_ci),
    .rd_idx   (spr_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_ppn   (rd_ppn),
    .rd_perm  (rd_perm),
    .rd_ci    (rd_ci)
  );

  dtlb_lookup #(.TAG_W(TAG_W), .PPN_W(PPN_W)) u_lookup (
    .clk       (clk),
    .rst       (rst),
    .fire      (lk_fire),
    .va_tag    (lookup_va[31 -: TAG_W]),
    .row_valid (lk_valid),
    .row_tag   (lk_tag),
    .row_ppn   (lk_ppn),
    .row_perm  (lk_perm),
    .row_ci    (lk_ci),
    .hit       (hit_o),
    .ppn       (ppn_o),
    .perm      (out_perm),
    .ci        (ci_o)
  );

  assign swe_o = out_perm.swe;
  assign sre_o = out_perm.sre;
  assign uwe_o = out_perm.uwe;
  assign ure_o = out_perm.ure;

  always_comb begin
    spr_rdata = 32'h0;
    if (rd_en) begin
      if (rd_xlat)
        spr_rdata = pack_xlat(32'(rd_ppn) << PAGE_SHIFT, rd_perm, rd_ci);
      else
        spr_rdata = pack_match(32'(rd_tag) << (32 - TAG_W), rd_valid);
    end
  end

  assign unused_bits = ^{lookup_va[PAGE_SHIFT-1:0], spr_wdata[PAGE_SHIFT-1:POS_SWE+1],
                         spr_wdata[POS_URE-1:POS_CI+1]};

endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker #(
  parameter int IDX_W = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        lookup_en,
  input logic        lk_fire,
  input logic        hit_o,
  input logic        spr_cs,
  input logic        spr_we,
  input logic [31:0] spr_addr,
  input logic        wdata_v,
  input logic [31:0] spr_rdata
);

  logic [7:0] hi_mask;
  logic       in_tag_win;
  logic       in_map_win;
  logic       any_win;
  logic       valid_written_q;

  assign hi_mask    = ~8'((1 << IDX_W) - 1);
  assign in_tag_win = (spr_addr[31:8] == 24'h00000A) && ((spr_addr[7:0] & hi_mask) == 8'h00);
  assign in_map_win = (spr_addr[31:8] == 24'h00000B) && ((spr_addr[7:0] & hi_mask) == 8'h00);
  assign any_win    = in_tag_win || in_map_win;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) valid_written_q <= 1'b0;
    else if (spr_cs && spr_we && in_tag_win && wdata_v) valid_written_q <= 1'b1;
  end

  // R1: nothing can hit before some entry was made valid
  p_no_hit_before_fill_r1: assert property (@(posedge clk) disable iff (rst)
    !valid_written_q |-> !hit_o);

  // R4: read data is quiet outside window reads
  p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!spr_cs || spr_we || !any_win) |-> (spr_rdata == 32'h0));

  // R5: a hit always traces back to an accepted lookup
  p_hit_from_fire_r5: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(lk_fire));

  // R8: register access wins over a same-cycle lookup
  p_spr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    $past(lookup_en && spr_cs && any_win) |-> !hit_o);

  // R9: no lookup, no hit
  p_idle_no_hit_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(lookup_en) |-> !hit_o);

endmodule

bind dtlb_top dtlb_checker #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lookup_en (lookup_en),
  .lk_fire   (lk_fire),
  .hit_o     (hit_o),
  .spr_cs    (spr_cs),
  .spr_we    (spr_we),
  .spr_addr  (spr_addr),
  .wdata_v   (spr_wdata[0]),
  .spr_rdata (spr_rdata)
);

// File: tb/dtlb_top_test.sv
`timescale 1ns/1ps
module dtlb_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_en = 1'b0;
  logic [31:0] lookup_va = '0;
  logic        hit_o, ure_o, uwe_o, sre_o, swe_o, ci_o;
  logic [18:0] ppn_o;
  logic        spr_cs = 1'b0, spr_we = 1'b0;
  logic [31:0] spr_addr = '0, spr_wdata = '0;
  logic [31:0] spr_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dtlb_top uut (
    .clk(clk), .rst(rst), .lookup_en(lookup_en), .lookup_va(lookup_va),
    .hit_o(hit_o), .ppn_o(ppn_o), .ure_o(ure_o), .uwe_o(uwe_o),
    .sre_o(sre_o), .swe_o(swe_o), .ci_o(ci_o), .spr_cs(spr_cs),
    .spr_we(spr_we), .spr_addr(spr_addr), .spr_wdata(spr_wdata),
    .spr_rdata(spr_rdata)
  );

  typedef struct {
    logic        hit;
    logic [18:0] ppn;
    logic [3:0]  perm;
    logic        ci;
    string       req;
  } exp_t;

  exp_t        sb[$];
  exp_t        cur;
  logic [31:0] m_word [64];
  logic [31:0] t_word [64];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [31:0] va, input string req);
    exp_t e;
    logic [5:0] i;
    i      = va[18:13];
    e.hit  = m_word[i][0] && (m_word[i][31:19] == va[31:19]);
    e.ppn  = t_word[i][31:13];
    e.perm = t_word[i][9:6];
    e.ci   = t_word[i][1];
    e.req  = req;
    return e;
  endfunction

  function automatic exp_t miss_item(input string req);
    exp_t e;
    e.hit = 1'b0; e.ppn = '0; e.perm = '0; e.ci = 1'b0; e.req = req;
    return e;
  endfunction

  task automatic model_write(input logic [31:0] a, input logic [31:0] d);
    if (a[31:8] == 24'h00000A && a[7:6] == 2'b00) m_word[a[5:0]] = d & 32'hFFF8_0001;
    if (a[31:8] == 24'h00000B && a[7:6] == 2'b00) t_word[a[5:0]] = d & 32'hFFFF_E3C2;
  endtask

  // Monitor: one expected item per issued cycle, compared after the edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      check(hit_o == cur.hit, cur.req, 32'(hit_o), 32'(cur.hit));
      if (cur.hit) begin
        check(ppn_o == cur.ppn, cur.req, 32'(ppn_o), 32'(cur.ppn));
        check({swe_o, sre_o, uwe_o, ure_o} == cur.perm, cur.req,
              32'({swe_o, sre_o, uwe_o, ure_o}), 32'(cur.perm));
        check(ci_o == cur.ci, cur.req, 32'(ci_o), 32'(cur.ci));
      end
    end
  end

  task automatic do_lookup(input logic [31:0] va, input string req);
    @(negedge clk);
    lookup_en = 1'b1; lookup_va = va; spr_cs = 1'b0; spr_we = 1'b0;
    sb.push_back(predict(va, req));
  endtask

  task automatic do_idle(input string req);
    @(negedge clk);
    lookup_en = 1'b0; spr_cs = 1'b0; spr_we = 1'b0;
    sb.push_back(miss_item(req));
  endtask

  task automatic spr_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    lookup_en = 1'b0; spr_cs = 1'b1; spr_we = 1'b1; spr_addr = a; spr_wdata = d;
    model_write(a, d);
  endtask

  task automatic spr_read(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    lookup_en = 1'b0; spr_cs = 1'b1; spr_we = 1'b0; spr_addr = a; spr_wdata = '0;
    #1;
    check(spr_rdata == exp, req, spr_rdata, exp);
  endtask

  task automatic lookup_with_write(input logic [31:0] va, input logic [31:0] a,
                                   input logic [31:0] d);
    @(negedge clk);
    lookup_en = 1'b1; lookup_va = va;
    spr_cs = 1'b1; spr_we = 1'b1; spr_addr = a; spr_wdata = d;
    sb.push_back(miss_item("R8 register access wins"));
    model_write(a, d);
  endtask

  function automatic logic [31:0] va_of(input logic [12:0] tag, input logic [5:0] idx);
    return {tag, idx, 13'h0ABC};
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_word[i] = '0; t_word[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check(hit_o == 1'b0, "R1 hit during reset", 32'(hit_o), 32'h0);
    check(spr_rdata == 32'h0, "R1 rdata during reset", spr_rdata, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R1: cleared entries
    do_lookup(va_of(13'h0, 6'd0), "R1 miss after reset");
    do_lookup(va_of(13'h1ABC, 6'd63), "R1 miss after reset");
    spr_read(32'h0A05, 32'h0, "R1 tag word cleared");
    spr_read(32'h0B05, 32'h0, "R1 mapping word cleared");

    // R2 R3 R5: program entry 3 and look it up
    spr_write(32'h0A03, {13'h1234, 18'h0, 1'b1});
    spr_write(32'h0B03, {19'h5A5A5, 3'b0, 4'b1010, 4'b0, 1'b1, 1'b0});
    do_lookup(va_of(13'h1234, 6'd3), "R5 hit entry 3");
    do_idle("R9 idle after lookup");

    // R4: readback with all bits set
    spr_write(32'h0A0A, 32'hFFFF_FFFF);
    spr_write(32'h0B0A, 32'hFFFF_FFFF);
    spr_read(32'h0A0A, 32'hFFF8_0001, "R4 R2 tag word layout");
    spr_read(32'h0B0A, 32'hFFFF_E3C2, "R4 R3 mapping word layout");
    spr_read(32'h0A03, {13'h1234, 18'h0, 1'b1}, "R4 tag word entry 3");
    spr_read(32'h0C03, 32'h0, "R4 read outside window");
    do_lookup(va_of(13'h1FFF, 6'd10), "R3 all permissions set");

    // R6: tag mismatch and invalid entry
    do_lookup(va_of(13'h1235, 6'd3), "R6 tag mismatch");
    do_lookup(va_of(13'h0234, 6'd3), "R6 top tag bit differs");
    spr_write(32'h0A03, {13'h1234, 18'h0, 1'b0});
    do_lookup(va_of(13'h1234, 6'd3), "R6 valid clear");

    // R7: rewrite tag word only, mapping unchanged
    spr_write(32'h0A03, {13'h0777, 18'h0, 1'b1});
    spr_read(32'h0B03, {19'h5A5A5, 3'b0, 4'b1010, 4'b0, 1'b1, 1'b0}, "R7 mapping kept");
    spr_write(32'h0B03, {19'h00011, 13'h0040});
    spr_read(32'h0A03, {13'h0777, 18'h0, 1'b1}, "R7 tag kept");
    do_lookup(va_of(13'h0777, 6'd3), "R7 both halves");

    // R10: writes outside the windows
    spr_write(32'h0A40, 32'hFFFF_FFFF);
    spr_write(32'h0C03, 32'hFFFF_FFFF);
    spr_write(32'h1A00, 32'hFFFF_FFFF);
    spr_read(32'h0A00, 32'h0, "R10 entry 0 untouched");
    spr_read(32'h0B03, {19'h00011, 13'h0040}, "R10 entry 3 untouched");

    // R8: lookup collides with a register write to the same entry
    lookup_with_write(va_of(13'h0777, 6'd3), 32'h0A03, {13'h0777, 18'h0, 1'b1});
    do_lookup(va_of(13'h0777, 6'd3), "R8 next lookup hits");

    // R5: fill all entries, back-to-back lookups
    for (int i = 0; i < 64; i++) begin
      spr_write(32'h0A00 + i, {13'(i * 97 + 5), 18'h0, 1'b1});
      spr_write(32'h0B00 + i, {19'(i * 4099 + 1), 3'b0, 4'(i), 4'b0, 1'(i % 3 == 0), 1'b0});
    end
    for (int i = 0; i < 64; i++) do_lookup(va_of(13'(i * 97 + 5), 6'(i)), "R5 sweep hit");
    for (int i = 0; i < 8; i++) do_lookup(va_of(13'(i * 97 + 6), 6'(i)), "R6 sweep miss");
    do_idle("R9 idle");
    do_idle("R9 idle");
    repeat (3) @(negedge clk);
    spr_cs = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule